// File: doc/BRIEF.md
# Average-Current PWM Boost Controller

This block closes a slow control loop around a synchronous boost stage that sets the bias voltage of an LED string. It compares a measured load current with a lighting setpoint and trims the PWM duty cycle of the boost switches once per switching period. The goal is to hold the average load current at the setpoint while the load voltage drifts slowly with temperature. The default timing assumes a 100 MHz clock and a 1000-cycle period, which gives 100 kHz switching. Fast transient response is not a goal.

Current samples arrive on a valid/ready stream. The block takes a sample in any cycle where both `meas_valid` and `meas_ready` are high. `meas_ready` drops only during reset, so the block never applies back-pressure in normal operation. A sender that holds `meas_valid` high simply has each new word accepted. The setpoint is a plain level input. The loop reads it at each regulation update.

The two gate outputs drive the main switch and the synchronous switch of the boost stage. They are complementary, with a fixed dead band at every hand-over. A discrete PI law computes the duty. Its integrator is limited to the duty range, so it cannot wind up.

Top module: `boost_avg_ctl`

## Requirements
- R1: While reset is asserted, `gate_main`, `gate_sync` and `meas_ready` are all low. In the first period after reset, the duty is DMIN, so `gate_main` is high for DMIN-DEAD cycles.
- R2: `gate_main` and `gate_sync` are never high in the same cycle. In each period the main pulse comes first and the synchronous pulse follows it.
- R3: At every hand-over between the gates, both gates are low for exactly DEAD cycles. This applies from main to sync and from sync to the next main.
- R4: With duty D counts, `gate_main` is high for D-DEAD cycles and `gate_sync` is high for PERIOD-D-DEAD cycles. So one main pulse, one sync pulse and two dead bands together fill exactly PERIOD cycles.
- R5: A new duty value takes effect only at the start of a period. The duty in use never changes inside a period.
- R6: The duty is always within [DMIN, DMAX]. A setpoint far above or below what the load can reach pins the duty at DMAX or DMIN.
- R7: Once per period, at counter value PERIOD-2, the loop updates. The error is setpoint minus the latest accepted sample. The integrator adds the error. The new duty is (integrator >>> KI_SH) + (error >>> KP_SH). In closed loop, the measured current settles at the setpoint.
- R8: The integrator is clamped to [DMIN<<KI_SH, DMAX<<KI_SH]. After a long stretch at a duty limit, the duty leaves that limit at the first update where the error reverses.
- R9: `meas_ready` goes high on the first clock edge after reset is released and stays high. A word is accepted when valid and ready are both high. The latest accepted word is used; if no new word arrives, the previous one is reused.
- R10: A change of `sp_code` is picked up at the next update. The loop then moves to the new operating point with no other action needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sp_code | input | MW | Current setpoint, in the same units as the samples |
| meas_valid | input | 1 | Current sample valid |
| meas_ready | output | 1 | Sample accept; low only in reset |
| meas_data | input | MW | Measured load current |
| gate_main | output | 1 | Main (low-side) switch gate |
| gate_sync | output | 1 | Synchronous switch gate |

## Verification
A sample accepted before counter value PERIOD-2 of period k sets the duty that is loaded at the start of period k+1. The gates are registered, so they lag the period counter by one cycle. The bench therefore never compares duty per cycle. It reads each main and sync pulse width on the falling edge of the pulse, sampling on the negative clock edge. It evaluates a regulation result only after 150 periods at a setpoint, which is many loop time constants. The anti-windup check allows three periods after a setpoint drop: one period for the update, one for the load, and one as margin. Dead-band lengths and the per-period width sum are checked on every period of the run.

// File: rtl/bst_ctl_pkg.sv
package bst_ctl_pkg;
  // phase of the switching period, decoded from the period counter
  typedef enum logic [1:0] {
    PH_LEAD = 2'd0,  // dead band before the main pulse
    PH_MAIN = 2'd1,  // main switch on
    PH_MID  = 2'd2,  // dead band between main and sync
    PH_SYNC = 2'd3   // synchronous switch on
  } gate_phase_e;
endpackage

// File: rtl/bst_period_timer.sv
module bst_period_timer #(
  parameter int PERIOD = 1000,
  parameter int CW     = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt,
  output logic          at_last,
  output logic          at_update
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] UPD  = CW'(PERIOD - 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign at_last   = (cnt == LAST);
  assign at_update = (cnt == UPD);
endmodule

// File: rtl/bst_meas_port.sv
module bst_meas_port #(
  parameter int MW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [MW-1:0] in_data,
  output logic [MW-1:0] held
);
  logic ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  held <= '0;
    else if (in_valid && ready_q) held <= in_data;
  end

  assign in_ready = ready_q;
endmodule

// File: rtl/bst_pi_core.sv
module bst_pi_core #(
  parameter int CW    = 10,
  parameter int MW    = 12,
  parameter int DMIN  = 50,
  parameter int DMAX  = 900,
  parameter int KP_SH = 3,
  parameter int KI_SH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [MW-1:0] sp,
  input  logic [MW-1:0] meas,
  output logic [CW-1:0] duty_cmd
);
  localparam int AW = (((CW + KI_SH) > MW) ? (CW + KI_SH) : MW) + 3;
  localparam logic signed [AW-1:0] ACC_LO = AW'(DMIN * (2 ** KI_SH));
  localparam logic signed [AW-1:0] ACC_HI = AW'(DMAX * (2 ** KI_SH));
  localparam logic signed [AW-1:0] D_LO   = AW'(DMIN);
  localparam logic signed [AW-1:0] D_HI   = AW'(DMAX);

  logic signed [MW:0]   err_s;
  logic signed [AW-1:0] err_x, acc_q, acc_sum, acc_nxt, p_term, d_sum, d_cl;
  logic        [CW-1:0] duty_q;

  assign err_s = $signed({1'b0, sp}) - $signed({1'b0, meas});
  assign err_x = {{(AW-MW-1){err_s[MW]}}, err_s};

  // integral path with saturation at the duty limits
  always_comb begin
    acc_sum = acc_q + err_x;
    if (acc_sum < ACC_LO)      acc_nxt = ACC_LO;
    else if (acc_sum > ACC_HI) acc_nxt = ACC_HI;
    else                       acc_nxt = acc_sum;
  end

  // proportional path and output clamp
  always_comb begin
    p_term = err_x >>> KP_SH;
    d_sum  = (acc_nxt >>> KI_SH) + p_term;
    if (d_sum < D_LO)      d_cl = D_LO;
    else if (d_sum > D_HI) d_cl = D_HI;
    else                   d_cl = d_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= ACC_LO;
      duty_q <= CW'(DMIN);
    end else if (upd) begin
      acc_q  <= acc_nxt;
      duty_q <= CW'(d_cl);
    end
  end

  assign duty_cmd = duty_q;
endmodule

// File: rtl/bst_gate_gen.sv
module bst_gate_gen
  import bst_ctl_pkg::*;
#(
  parameter int CW   = 10,
  parameter int DEAD = 5,
  parameter int DMIN = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          at_last,
  input  logic [CW-1:0] duty_cmd,
  output logic [CW-1:0] duty_live,
  output logic          gate_main,
  output logic          gate_sync
);
  localparam logic [CW:0] DEAD_X = (CW+1)'(DEAD);

  gate_phase_e phase;
  logic [CW:0] cnt_x, main_end, mid_end;

  // duty is loaded only on the last count, so it is in force from count 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       duty_live <= CW'(DMIN);
    else if (at_last) duty_live <= duty_cmd;
  end

  assign cnt_x    = {1'b0, cnt};
  assign main_end = {1'b0, duty_live};
  assign mid_end  = main_end + DEAD_X;

  always_comb begin
    if (cnt_x < DEAD_X)        phase = PH_LEAD;
    else if (cnt_x < main_end) phase = PH_MAIN;
    else if (cnt_x < mid_end)  phase = PH_MID;
    else                       phase = PH_SYNC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_main <= 1'b0;
      gate_sync <= 1'b0;
    end else begin
      gate_main <= (phase == PH_MAIN);
      gate_sync <= (phase == PH_SYNC);
    end
  end
endmodule

// File: rtl/boost_avg_ctl.sv
module boost_avg_ctl #(
  parameter int PERIOD = 1000,
  parameter int DEAD   = 5,
  parameter int DMIN   = 50,
  parameter int DMAX   = 900,
  parameter int MW     = 12,
  parameter int KP_SH  = 3,
  parameter int KI_SH  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] sp_code,
  input  logic          meas_valid,
  output logic          meas_ready,
  input  logic [MW-1:0] meas_data,
  output logic          gate_main,
  output logic          gate_sync
);
  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0] tick_cnt;
  logic          tick_last, tick_upd;
  logic [MW-1:0] meas_held;
  logic [CW-1:0] duty_cmd, duty_live;

  bst_period_timer #(.PERIOD(PERIOD), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .cnt(tick_cnt),
    .at_last(tick_last), .at_update(tick_upd)
  );

  bst_meas_port #(.MW(MW)) u_meas (
    .clk(clk), .rst_n(rst_n), .in_valid(meas_valid),
    .in_ready(meas_ready), .in_data(meas_data), .held(meas_held)
  );

  bst_pi_core #(
    .CW(CW), .MW(MW), .DMIN(DMIN), .DMAX(DMAX),
    .KP_SH(KP_SH), .KI_SH(KI_SH)
  ) u_pi (
    .clk(clk), .rst_n(rst_n), .upd(tick_upd),
    .sp(sp_code), .meas(meas_held), .duty_cmd(duty_cmd)
  );

  bst_gate_gen #(.CW(CW), .DEAD(DEAD), .DMIN(DMIN)) u_gate (
    .clk(clk), .rst_n(rst_n), .cnt(tick_cnt), .at_last(tick_last),
    .duty_cmd(duty_cmd), .duty_live(duty_live),
    .gate_main(gate_main), .gate_sync(gate_sync)
  );
endmodule

// File: rtl/bst_ctl_chk.sv
module bst_ctl_chk #(
  parameter int PERIOD = 1000,
  parameter int DEAD   = 5,
  parameter int DMIN   = 50,
  parameter int DMAX   = 900,
  parameter int CW     = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gate_main,
  input logic          gate_sync,
  input logic          meas_ready,
  input logic [CW-1:0] tick_cnt,
  input logic [CW-1:0] duty_cmd,
  input logic [CW-1:0] duty_live
);
  logic [CW-1:0] gap_q;
  logic          armed_q;

  // length of the current both-low stretch; armed after the first pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      gap_q   <= (!gate_main && !gate_sync) ? gap_q + 1'b1 : '0;
      armed_q <= armed_q | gate_main | gate_sync;
    end
  end

  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_main && gate_sync));

  p_gap_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && ($rose(gate_main) || $rose(gate_sync))) |-> (gap_q == CW'(DEAD)));

  p_cmd_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_cmd >= CW'(DMIN)) && (duty_cmd <= CW'(DMAX)));

  p_live_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_live >= CW'(DMIN)) && (duty_live <= CW'(DMAX)));

  p_duty_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_cnt != '0) |-> $stable(duty_live));

  p_ready_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> meas_ready);
endmodule

bind boost_avg_ctl bst_ctl_chk #(
  .PERIOD(PERIOD), .DEAD(DEAD), .DMIN(DMIN), .DMAX(DMAX), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_main(gate_main), .gate_sync(gate_sync),
  .meas_ready(meas_ready), .tick_cnt(tick_cnt), .duty_cmd(duty_cmd),
  .duty_live(duty_live)
);

// File: tb/tb_boost_avg_ctl.sv
`timescale 1ns/1ps
module tb_boost_avg_ctl;
  localparam int PER = 100;
  localparam int DT  = 3;
  localparam int DMN = 5;
  localparam int DMX = 90;
  localparam int MW  = 12;
  localparam int NV  = 5;
  // setpoint, expected main width, expected sync width, tolerance, clamp row
  localparam int VEC [NV][5] = '{
    '{200,  47, 47, 2, 0},
    '{120,  27, 67, 2, 0},
    '{4000, 87,  7, 0, 1},
    '{300,  72, 22, 2, 0},
    '{0,     2, 92, 0, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [MW-1:0] sp_code = '0;
  logic meas_valid = 1'b0;
  logic meas_ready;
  logic [MW-1:0] meas_data = '0;
  logic gate_main, gate_sync;

  always #2 clk = ~clk;

  boost_avg_ctl #(
    .PERIOD(PER), .DEAD(DT), .DMIN(DMN), .DMAX(DMX),
    .MW(MW), .KP_SH(3), .KI_SH(4)
  ) dut (
    .clk(clk), .rst_n(rst_n), .sp_code(sp_code), .meas_valid(meas_valid),
    .meas_ready(meas_ready), .meas_data(meas_data),
    .gate_main(gate_main), .gate_sync(gate_sync)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int period_cnt = 0, last_m = 0, last_s = 0;
  int overlap_n = 0, gap_bad = 0, gaps_seen = 0, pair_bad = 0, pairs_seen = 0;
  int i_fx = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // port monitor plus first-order load model (current = 4 codes per duty count)
  initial begin
    int run_m, run_s, gap;
    bit pm, ps, armed;
    run_m = 0; run_s = 0; gap = 0; pm = 0; ps = 0; armed = 0;
    forever begin
      @(negedge clk);
      meas_valid = 1'b0;
      if (rst_n) begin
        if (gate_main && gate_sync) overlap_n++;
        if ((gate_main && !pm) || (gate_sync && !ps)) begin
          if (armed) begin
            gaps_seen++;
            if (gap != DT) gap_bad++;
          end
          armed = 1'b1;
        end
        gap = (!gate_main && !gate_sync) ? gap + 1 : 0;
        if (gate_main) run_m++;
        if (gate_sync) run_s++;
        if (pm && !gate_main) begin
          int cur;
          last_m = run_m; run_m = 0; period_cnt++;
          i_fx = i_fx + ((last_m + DT) * 64 - i_fx) / 8;
          cur = i_fx / 16;
          if (cur > 4095) cur = 4095;
          if (cur < 0) cur = 0;
          meas_data = MW'(cur);
          meas_valid = 1'b1;
        end
        if (ps && !gate_sync) begin
          last_s = run_s; run_s = 0; pairs_seen++;
          if (last_m + last_s + 2 * DT != PER) pair_bad++;
        end
        pm = gate_main; ps = gate_sync;
      end
    end
  end

  task automatic run_periods(input int n);
    int target;
    target = period_cnt + n;
    wait (period_cnt >= target);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", period_cnt, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    sp_code = 12'd200;
    repeat (5) @(negedge clk);
    // R1: reset state at the ports
    chk(!gate_main && !gate_sync, "R1 gates in reset", int'(gate_main) + int'(gate_sync), 0);
    chk(!meas_ready, "R1 ready in reset", int'(meas_ready), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(meas_ready == 1'b1, "R9 ready after reset", int'(meas_ready), 1);
    run_periods(1);
    chk(last_m == DMN - DT, "R1 first main width", last_m, DMN - DT);

    // table walk: each row sets a new setpoint mid-run (R10) and waits to settle
    for (int v = 0; v < NV; v++) begin
      string tag;
      sp_code = MW'(VEC[v][0]);
      run_periods(150);
      tag = (VEC[v][4] != 0) ? "R6 clamp" : "R7 R10 settle";
      chk((last_m >= VEC[v][1] - VEC[v][3]) && (last_m <= VEC[v][1] + VEC[v][3]),
          {tag, " main width"}, last_m, VEC[v][1]);
      chk((last_s >= VEC[v][2] - VEC[v][3]) && (last_s <= VEC[v][2] + VEC[v][3]),
          {tag, " sync width"}, last_s, VEC[v][2]);
      if (VEC[v][4] == 0) begin
        int cur;
        cur = int'(meas_data);
        chk((cur >= VEC[v][0] - 12) && (cur <= VEC[v][0] + 12),
            "R7 current at setpoint", cur, VEC[v][0]);
      end
    end

    // R8: long saturation at the top, then the error reverses
    sp_code = 12'd4000;
    run_periods(60);
    chk(last_m == DMX - DT, "R8 saturated main width", last_m, DMX - DT);
    sp_code = 12'd120;
    run_periods(3);
    chk(last_m <= 70, "R8 leaves limit after reversal", last_m, 70);

    // whole-run pulse structure
    chk(overlap_n == 0, "R2 gate overlap cycles", overlap_n, 0);
    chk(gaps_seen > 0 && gap_bad == 0, "R3 dead band length", gap_bad, 0);
    chk(pairs_seen > 0 && pair_bad == 0, "R4 period fill", pair_bad, 0);
    chk(pair_bad == 0, "R5 duty constant within period", pair_bad, 0);
    chk(meas_ready == 1'b1, "R9 ready stays high", int'(meas_ready), 1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule